// File: doc/BRIEF.md
# Flash Block Health Monitor

The monitor keeps reliability statistics for every erase block of a small NAND array and turns them into maintenance requests for the controller's sequencer. The sequencer reports one event per cycle. Each event carries a block index, a type, a corrected-bit count for reads, and a pass/fail flag for program and erase. Each block holds a saturating read counter since its last erase, the largest corrected-bit count seen, a copy-back counter, a count of consecutive uncorrectable reads, and a retired flag.

When an event meets a policy condition, the monitor computes one request code for that block. If several conditions hold for the same event, the one with the highest priority wins and the rest are dropped. The request goes into a four-entry FIFO that the sequencer drains over a valid/ready handshake. A request that finds the FIFO full is lost and sets a sticky overflow flag. An uncorrectable read that has used up its retries also pulses a host-error output for one cycle, together with the block index.

The read-disturb limit and the copy-back limit are inputs. A read limit near one million suits typical parts.

Top module: `flash_health_mon`

## Requirements
- R1: A read or an uncorrectable read (event type 0 or 1) that takes a block's read count above `rd_limit_i` pushes a refresh request (code 1), once per erase cycle.
- R2: A successful erase (type 3, fail low) clears the block's read count, so the refresh comes back after `rd_limit_i`+1 further reads.
- R3: A read whose corrected-bit count reaches three quarters of the ECC capability (72 of 96 bits) pushes a retire request (code 2) and retires the block. A count one below that pushes nothing.
- R4: A failed program (type 2, fail high) pushes a move-then-erase request (code 5). The block stays in service and later failures request again.
- R5: A failed erase pushes a remap request (code 3) and retires the block.
- R6: A retired block pushes no further request, whatever event it receives.
- R7: A copy-back completion (type 4) that takes the block's copy-back count above `cb_limit_i` pushes an ECC-checked copy request (code 4) and resets that count to zero.
- R8: The first two consecutive uncorrectable reads of a block push a re-read request (code 6). The third pushes a refresh (code 1) and pulses `host_err_o` with the block index one cycle later. A correctable read resets the run.
- R9: Priority, from highest: erase failure, uncorrectable read, ECC margin, program failure, read disturb, copy-back.
- R10: A request shows on `req_valid_o` in the cycle after its event. Requests leave in arrival order, and an entry holds steady while `req_ready_i` is low.
- R11: A request that arrives while four entries are queued is dropped and sets `ovf_o`, which stays set until reset.
- R12: During and right after reset, `req_valid_o`, `ovf_o` and `host_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event present this cycle |
| evt_type_i | input | 3 | 0 read, 1 uncorrectable read, 2 program, 3 erase, 4 copy-back |
| evt_blk_i | input | 3 | Block index of the event |
| evt_bits_i | input | 7 | Corrected-bit count of a read |
| evt_fail_i | input | 1 | Program or erase failed |
| rd_limit_i | input | 21 | Read-disturb limit |
| cb_limit_i | input | 8 | Copy-back limit |
| req_valid_o | output | 1 | Request available |
| req_ready_i | input | 1 | Sequencer takes the request |
| req_code_o | output | 3 | Request code |
| req_blk_o | output | 3 | Block index of the request |
| ovf_o | output | 1 | Sticky request-drop flag |
| host_err_o | output | 1 | Unrecoverable read pulse |
| host_err_blk_o | output | 3 | Block of the unrecoverable read |

## Verification
The assertions check the queue interface on every cycle. They confirm that outputs are idle under reset, that the overflow flag never clears, that a stalled request holds its code and block, that a new request only follows an event, and that a host error only follows an uncorrectable read. The bench's scenarios are the only evidence for the per-block policy. That covers the thresholds at their exact crossing points, the one-shot refresh and its rearming by erase, the retired state, the reset of the copy-back and retry counts, the winner when two conditions meet in one event, and the FIFO's ordering and drop behaviour.

// File: rtl/fbhm_pkg.sv
package fbhm_pkg;
  typedef enum logic [2:0] {
    EV_READ     = 3'd0,
    EV_UNCORR   = 3'd1,
    EV_PROG     = 3'd2,
    EV_ERASE    = 3'd3,
    EV_COPYBACK = 3'd4
  } evt_e;

  typedef enum logic [2:0] {
    RQ_NONE       = 3'd0,
    RQ_REFRESH    = 3'd1,
    RQ_RETIRE     = 3'd2,
    RQ_REMAP      = 3'd3,
    RQ_ECC_COPY   = 3'd4,
    RQ_MOVE_ERASE = 3'd5,
    RQ_REREAD     = 3'd6
  } req_e;

  // field order is the priority order, highest first
  typedef struct packed {
    logic erase_fail;
    logic uncorr_final;
    logic uncorr_retry;
    logic margin;
    logic prog_fail;
    logic disturb;
    logic copyback;
  } cond_t;
endpackage

// File: rtl/fbhm_blk_stats.sv
module fbhm_blk_stats
  import fbhm_pkg::*;
#(
  parameter int RD_W   = 21,
  parameter int BITS_W = 7,
  parameter int CB_W   = 8,
  parameter int MARGIN = 72,
  parameter int TRIES  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [2:0]        evt_type_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic              fail_i,
  input  logic [RD_W-1:0]   rd_limit_i,
  input  logic [CB_W-1:0]   cb_limit_i,
  output cond_t             cond_o
);
  localparam int RT_W = (TRIES > 1) ? $clog2(TRIES) : 1;
  localparam logic [BITS_W-1:0] MARGIN_L = BITS_W'(MARGIN);
  localparam logic [RT_W-1:0]   RT_LAST  = RT_W'(TRIES - 1);

  logic [RD_W-1:0]   rd_q, rd_d;
  logic [BITS_W-1:0] worst_q, worst_d;
  logic [CB_W-1:0]   cb_q, cb_d;
  logic [RT_W-1:0]   rt_q, rt_d;
  logic              ret_q, ret_d;
  cond_t             cond;

  always_comb begin
    cond    = '0;
    rd_d    = rd_q;
    worst_d = worst_q;
    cb_d    = cb_q;
    rt_d    = rt_q;
    ret_d   = ret_q;
    if (hit_i && !ret_q) begin
      case (evt_e'(evt_type_i))
        EV_READ, EV_UNCORR: begin
          if (rd_q != '1) rd_d = rd_q + 1'b1;
          // fires only on the crossing into limit+1
          cond.disturb = (rd_q == rd_limit_i) && (rd_q != '1);
          if (evt_type_i == EV_READ) begin
            rt_d = '0;
            if (bits_i > worst_q) worst_d = bits_i;
            cond.margin = (worst_q < MARGIN_L) && (bits_i >= MARGIN_L);
            if (cond.margin) ret_d = 1'b1;
          end else if (rt_q >= RT_LAST) begin
            cond.uncorr_final = 1'b1;
            rt_d = '0;
          end else begin
            cond.uncorr_retry = 1'b1;
            rt_d = rt_q + 1'b1;
          end
        end
        EV_PROG: cond.prog_fail = fail_i;
        EV_ERASE: begin
          if (fail_i) begin
            cond.erase_fail = 1'b1;
            ret_d = 1'b1;
          end else begin
            rd_d    = '0;
            worst_d = '0;
            rt_d    = '0;
          end
        end
        EV_COPYBACK: begin
          if (cb_q >= cb_limit_i) begin
            cond.copyback = 1'b1;
            cb_d = '0;
          end else begin
            cb_d = cb_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      worst_q <= '0;
      cb_q    <= '0;
      rt_q    <= '0;
      ret_q   <= 1'b0;
    end else begin
      rd_q    <= rd_d;
      worst_q <= worst_d;
      cb_q    <= cb_d;
      rt_q    <= rt_d;
      ret_q   <= ret_d;
    end
  end

  assign cond_o = cond;
endmodule

// File: rtl/fbhm_arbiter.sv
module fbhm_arbiter
  import fbhm_pkg::*;
(
  input  cond_t      cond_i,
  output logic [2:0] code_o,
  output logic       host_err_o
);
  req_e code;

  always_comb begin
    if      (cond_i.erase_fail)   code = RQ_REMAP;
    else if (cond_i.uncorr_final) code = RQ_REFRESH;
    else if (cond_i.uncorr_retry) code = RQ_REREAD;
    else if (cond_i.margin)       code = RQ_RETIRE;
    else if (cond_i.prog_fail)    code = RQ_MOVE_ERASE;
    else if (cond_i.disturb)      code = RQ_REFRESH;
    else if (cond_i.copyback)     code = RQ_ECC_COPY;
    else                          code = RQ_NONE;
  end

  assign code_o     = code;
  assign host_err_o = cond_i.uncorr_final && !cond_i.erase_fail;
endmodule

// File: rtl/fbhm_req_fifo.sv
module fbhm_req_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_FULL);
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = valid_o && ready_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/flash_health_mon.sv
module flash_health_mon
  import fbhm_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int RD_W       = 21,
  parameter int ECC_CAP    = 96,
  parameter int CB_W       = 8,
  parameter int TRIES      = 3,
  parameter int FIFO_DEPTH = 4,
  localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int BITS_W    = $clog2(ECC_CAP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [2:0]        evt_type_i,
  input  logic [BLK_W-1:0]  evt_blk_i,
  input  logic [BITS_W-1:0] evt_bits_i,
  input  logic              evt_fail_i,
  input  logic [RD_W-1:0]   rd_limit_i,
  input  logic [CB_W-1:0]   cb_limit_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [2:0]        req_code_o,
  output logic [BLK_W-1:0]  req_blk_o,
  output logic              ovf_o,
  output logic              host_err_o,
  output logic [BLK_W-1:0]  host_err_blk_o
);
  localparam int MARGIN = (ECC_CAP * 3) / 4;
  localparam int ENT_W  = 3 + BLK_W;

  cond_t            cond_arr [NUM_BLOCKS];
  cond_t            cond_any;
  logic [2:0]       code;
  logic             herr;
  logic             push, full;
  logic [ENT_W-1:0] head;
  logic             ovf_q, herr_q;
  logic [BLK_W-1:0] herr_blk_q;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    fbhm_blk_stats #(
      .RD_W(RD_W), .BITS_W(BITS_W), .CB_W(CB_W), .MARGIN(MARGIN), .TRIES(TRIES)
    ) i_stats (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hit_i      (evt_valid_i && (evt_blk_i == BLK_W'(b))),
      .evt_type_i (evt_type_i),
      .bits_i     (evt_bits_i),
      .fail_i     (evt_fail_i),
      .rd_limit_i (rd_limit_i),
      .cb_limit_i (cb_limit_i),
      .cond_o     (cond_arr[b])
    );
  end

  always_comb begin
    cond_any = '0;
    for (int b = 0; b < NUM_BLOCKS; b++) cond_any = cond_t'(cond_any | cond_arr[b]);
  end

  fbhm_arbiter i_arb (
    .cond_i     (cond_any),
    .code_o     (code),
    .host_err_o (herr)
  );

  assign push = (code != RQ_NONE);

  fbhm_req_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  ({code, evt_blk_i}),
    .full_o  (full),
    .valid_o (req_valid_o),
    .ready_i (req_ready_i),
    .data_o  (head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q      <= 1'b0;
      herr_q     <= 1'b0;
      herr_blk_q <= '0;
    end else begin
      if (push && full) ovf_q <= 1'b1;
      herr_q <= herr;
      if (herr) herr_blk_q <= evt_blk_i;
    end
  end

  assign req_code_o     = head[ENT_W-1:BLK_W];
  assign req_blk_o      = head[BLK_W-1:0];
  assign ovf_o          = ovf_q;
  assign host_err_o     = herr_q;
  assign host_err_blk_o = herr_blk_q;
endmodule

// File: rtl/fbhm_chk.sv
module fbhm_chk #(
  parameter int BLK_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_valid_i,
  input logic [2:0]       evt_type_i,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic [2:0]       req_code_o,
  input logic [BLK_W-1:0] req_blk_o,
  input logic             ovf_o,
  input logic             host_err_o
);
  // R12
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!req_valid_o && !ovf_o && !host_err_o));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_code_o) && $stable(req_blk_o)));

  // R10
  req_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(evt_valid_i));

  // R10
  req_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_code_o != 3'd0) && (req_code_o != 3'd7));

  // R8
  herr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_err_o |-> $past(evt_valid_i && (evt_type_i == 3'd1)));
endmodule

bind flash_health_mon fbhm_chk #(.BLK_W(BLK_W)) i_fbhm_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_i (evt_valid_i),
  .evt_type_i  (evt_type_i),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_code_o  (req_code_o),
  .req_blk_o   (req_blk_o),
  .ovf_o       (ovf_o),
  .host_err_o  (host_err_o)
);

// File: tb/test_flash_health_mon.sv
module test_flash_health_mon;
  localparam int RD = 0, UC = 1, PG = 2, ER = 3, CB = 4;
  localparam int C_REF = 1, C_RET = 2, C_MAP = 3, C_ECC = 4, C_MOV = 5, C_RRD = 6;

  typedef struct packed {
    logic [2:0] ev;
    logic [2:0] blk;
    logic [6:0] bits;
    logic       fail;
    logic       exp_v;
    logic [2:0] code;
    logic       herr;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VECS [NV] = '{
    // R1: limit 4, fifth read crosses
    '{RD, 0, 10, 0, 0, 0,     0, 1},
    '{RD, 0, 20, 0, 0, 0,     0, 1},
    '{RD, 0,  5, 0, 0, 0,     0, 1},
    '{RD, 0,  5, 0, 0, 0,     0, 1},
    '{RD, 0,  5, 0, 1, C_REF, 0, 1},
    '{RD, 0,  5, 0, 0, 0,     0, 1},
    // R2: erase rearms the refresh
    '{ER, 0,  0, 0, 0, 0,     0, 2},
    '{RD, 0,  0, 0, 0, 0,     0, 2},
    '{RD, 0,  0, 0, 0, 0,     0, 2},
    '{RD, 0,  0, 0, 0, 0,     0, 2},
    '{RD, 0,  0, 0, 0, 0,     0, 2},
    '{RD, 0,  0, 0, 1, C_REF, 0, 2},
    // R3: margin boundary
    '{RD, 1, 71, 0, 0, 0,     0, 3},
    '{RD, 1, 72, 0, 1, C_RET, 0, 3},
    // R6: retired block silent
    '{PG, 1,  0, 1, 0, 0,     0, 6},
    '{RD, 1, 90, 0, 0, 0,     0, 6},
    // R4: program failure keeps block in service
    '{PG, 2,  0, 1, 1, C_MOV, 0, 4},
    '{PG, 2,  0, 0, 0, 0,     0, 4},
    '{RD, 2,  0, 0, 0, 0,     0, 4},
    '{PG, 2,  0, 1, 1, C_MOV, 0, 4},
    // R5 then R6
    '{ER, 3,  0, 1, 1, C_MAP, 0, 5},
    '{ER, 3,  0, 0, 0, 0,     0, 6},
    '{ER, 3,  0, 1, 0, 0,     0, 6},
    // R7: limit 2, third copy-back crosses, then counter restarts
    '{CB, 4,  0, 0, 0, 0,     0, 7},
    '{CB, 4,  0, 0, 0, 0,     0, 7},
    '{CB, 4,  0, 0, 1, C_ECC, 0, 7},
    '{CB, 4,  0, 0, 0, 0,     0, 7},
    '{CB, 4,  0, 0, 0, 0,     0, 7},
    '{CB, 4,  0, 0, 1, C_ECC, 0, 7},
    // R8: retries then host error
    '{UC, 5,  0, 0, 1, C_RRD, 0, 8},
    '{UC, 5,  0, 0, 1, C_RRD, 0, 8},
    '{UC, 5,  0, 0, 1, C_REF, 1, 8},
    '{UC, 6,  0, 0, 1, C_RRD, 0, 8},
    '{RD, 6,  0, 0, 0, 0,     0, 8},
    '{UC, 6,  0, 0, 1, C_RRD, 0, 8},
    '{RD, 6,  0, 0, 0, 0,     0, 8},
    // R9: re-read beats read disturb (read count crosses here)
    '{UC, 6,  0, 0, 1, C_RRD, 0, 9},
    // R9: margin beats read disturb
    '{RD, 7,  0, 0, 0, 0,     0, 9},
    '{RD, 7,  0, 0, 0, 0,     0, 9},
    '{RD, 7,  0, 0, 0, 0,     0, 9},
    '{RD, 7,  0, 0, 0, 0,     0, 9},
    '{RD, 7, 80, 0, 1, C_RET, 0, 9},
    '{RD, 0,  0, 0, 0, 0,     0, 1}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_type = '0;
  logic [2:0]  evt_blk = '0;
  logic [6:0]  evt_bits = '0;
  logic        evt_fail = 1'b0;
  logic [20:0] rd_limit = 21'd4;
  logic [7:0]  cb_limit = 8'd2;
  logic        req_ready = 1'b1;
  logic        req_valid;
  logic [2:0]  req_code;
  logic [2:0]  req_blk;
  logic        ovf;
  logic        host_err;
  logic [2:0]  host_err_blk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  flash_health_mon i_flash_health_mon (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .evt_valid_i    (evt_valid),
    .evt_type_i     (evt_type),
    .evt_blk_i      (evt_blk),
    .evt_bits_i     (evt_bits),
    .evt_fail_i     (evt_fail),
    .rd_limit_i     (rd_limit),
    .cb_limit_i     (cb_limit),
    .req_valid_o    (req_valid),
    .req_ready_i    (req_ready),
    .req_code_o     (req_code),
    .req_blk_o      (req_blk),
    .ovf_o          (ovf),
    .host_err_o     (host_err),
    .host_err_blk_o (host_err_blk)
  );

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic drive(input int ev, input int blk, input int bits, input bit fail);
    evt_valid = 1'b1;
    evt_type  = 3'(ev);
    evt_blk   = 3'(blk);
    evt_bits  = 7'(bits);
    evt_fail  = fail;
  endtask

  function automatic int pack_out();
    return {req_valid, (req_valid ? req_code : 3'd0), (req_valid ? req_blk : 3'd0),
            host_err, (host_err ? host_err_blk : 3'd0)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R12: idle in reset
    check("R12", {req_valid, ovf, host_err}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R12", {req_valid, ovf, host_err}, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].ev, VECS[i].blk, VECS[i].bits, VECS[i].fail);
      @(negedge clk);
      check($sformatf("R%0d vec %0d", VECS[i].rq, i), pack_out(),
            {VECS[i].exp_v, (VECS[i].exp_v ? VECS[i].code : 3'd0),
             (VECS[i].exp_v ? VECS[i].blk : 3'd0),
             VECS[i].herr, (VECS[i].herr ? VECS[i].blk : 3'd0)});
    end

    // R10/R11: fill the queue with the sequencer stalled
    req_ready = 1'b0;
    drive(PG, 0, 0, 1'b1);
    @(negedge clk);
    check("R10 latency", {req_valid, req_blk}, {1'b1, 3'd0});
    drive(PG, 2, 0, 1'b1);
    @(negedge clk);
    drive(PG, 4, 0, 1'b1);
    @(negedge clk);
    drive(PG, 6, 0, 1'b1);
    @(negedge clk);
    check("R11 no drop yet", ovf, 0);
    check("R10 hold head", {req_valid, req_code, req_blk}, {1'b1, 3'(C_MOV), 3'd0});
    drive(PG, 5, 0, 1'b1);
    @(negedge clk);
    check("R11 overflow set", ovf, 1);
    evt_valid = 1'b0;
    req_ready = 1'b1;
    @(negedge clk);
    check("R10 order", {req_valid, req_blk}, {1'b1, 3'd2});
    @(negedge clk);
    check("R10 order", {req_valid, req_blk}, {1'b1, 3'd4});
    @(negedge clk);
    check("R10 order", {req_valid, req_blk}, {1'b1, 3'd6});
    @(negedge clk);
    check("R11 dropped entry absent", req_valid, 0);
    check("R11 sticky", ovf, 1);

    // R12: reset clears the sticky flag
    rst_ni = 1'b0;
    @(negedge clk);
    check("R12", {req_valid, ovf, host_err}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R12", {req_valid, ovf, host_err}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule